// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a 256-byte serial memory that answers as a slave on a two-wire bus. The system clock runs much faster than the bus clock, and the block samples SCL and SDA in that clock domain. It drives one output, an active-high pull-down enable that the pad ring turns into an open-drain SDA driver. The block finds START and STOP conditions, matches the addressing byte against a fixed family code and three strap pins, and takes a one-byte word address. It then either stores incoming bytes or streams stored bytes out.

The storage is a register file that comes out of reset holding all ones. Each accepted data byte goes into the register file at once. A STOP that closes a transfer which wrote data sends a one-cycle start pulse to an external program controller. While that controller reports busy, the slave answers nothing at all, so a bus master finds out when programming is done by repeating the write-addressing byte until it is acknowledged. A protect input blocks data writes while it is high.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The addressing byte is accepted when its upper seven bits equal binary 1010 followed by strap_i[2:0] (MSB first), and its last bit is the direction (1 = read, 0 = write). An accepted byte is acknowledged by pulling SDA low for the 9th clock.
- R2: When the addressing byte does not match, the slave gives no acknowledge and keeps SDA released for every later clock until the next START.
- R3: In a write, the word-address byte and each data byte are acknowledged. Each data byte is stored at the address counter, and the counter then advances. The STOP that ends a transfer which stored at least one byte raises prog_start_o for exactly one clock. A transfer that stored no data gives no pulse.
- R4: While prog_busy_i is high, no byte is acknowledged, including a matching addressing byte in either direction.
- R5: While wp_i is high, the addressing and word-address bytes are acknowledged but data bytes are not. Memory keeps its contents and no program pulse follows.
- R6: A read with no address phase returns the byte at the current address counter. That counter is the location after the last byte written or sent.
- R7: A random read works as follows: a write addressing byte, then a word address, then a repeated START and a read addressing byte. It returns the byte at that word address.
- R8: When the master acknowledges each byte of a read, the slave keeps sending bytes from consecutive addresses, and the counter wraps from 0xFF to 0x00.
- R9: When the master leaves SDA high on the 9th clock of a read byte, the slave stops sending and keeps SDA released until the next START.
- R10: After reset every location reads 0xFF, the address counter is 0, SDA is released and prog_start_o is low.
- R11: A START in the middle of a byte abandons that byte and begins a fresh addressing byte. A STOP in any state returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| strap_i | input | 3 | Strap pins forming the low three bits of the slave address |
| wp_i | input | 1 | Write protect, high blocks data writes |
| prog_busy_i | input | 1 | Busy flag from the external program controller |
| sda_pd_o | output | 1 | Pull SDA low when high |
| prog_start_o | output | 1 | One-cycle pulse asking the controller to program |

## Verification
Some rules are checked by the assertions on every cycle. SDA is never pulled while the slave is idle. A busy controller or an active protect input stops any acknowledge for the byte being decided. A START always clears the bit count and returns the slave to address decoding. The program pulse lasts only one cycle. Other behaviour can only be shown by the bench scenarios, because it depends on data stored earlier: that the right bytes come back from random, current-address and wrapping sequential reads; that polling finds the end of a program cycle; and that a protected write leaves memory unchanged.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_ADDR,
      ST_WDATA,
      ST_RDATA
   } ee_state_e;

   localparam logic [3:0] FAMILY_CODE = 4'b1010;
   localparam int BYTE_W = 8;
endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain;
   logic              prev;

   if (STAGES < 2) begin : g_bad_stages
      $error("ee_line_sync: STAGES must be at least 2");
   end

   if (STAGES == 2) begin : g_two
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[0], line_i};
      end
   end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], line_i};
      end
   end

   assign line_o = chain[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= line_o;
   end

   assign rise_o = line_o & ~prev;
   assign fall_o = ~line_o & prev;
endmodule

// File: rtl/ee_regfile.sv
module ee_regfile #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   if (AW < 1 || AW > 8) begin : g_bad_aw
      $error("ee_regfile: AW must be between 1 and 8");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
      end else if (we) begin
         cells[waddr] <= wdata;
      end
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/ee_slave_ctrl.sv
module ee_slave_ctrl
   import i2cee_pkg::*;
#(
   parameter int AW      = 8,
   parameter int STRAP_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_lvl,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               sda_lvl,
   input  logic               sda_rise,
   input  logic               sda_fall,
   input  logic [STRAP_W-1:0] strap,
   input  logic               wp,
   input  logic               busy,
   input  logic [BYTE_W-1:0]  rdata,
   output logic [AW-1:0]      ptr,
   output logic               we,
   output logic [BYTE_W-1:0]  wdata,
   output logic               sda_pd,
   output logic               prog_start
);
   ee_state_e         st, ret;
   logic [3:0]        bitcnt;
   logic [BYTE_W-1:0] shreg;
   logic              in_ack, mack, dirty;
   logic              start_c, stop_c, byte_done, id_match;

   if (4 + STRAP_W + 1 != BYTE_W) begin : g_bad_strap
      $error("ee_slave_ctrl: family code, straps and direction must fill one byte");
   end

   assign start_c   = scl_lvl & sda_fall;
   assign stop_c    = scl_lvl & sda_rise;
   assign byte_done = scl_fall & ~in_ack & (bitcnt == 4'd8);
   assign id_match  = (shreg[7:1] == {FAMILY_CODE, strap});
   assign we        = byte_done & (st == ST_WDATA) & ~wp;
   assign wdata     = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         ret        <= ST_IDLE;
         bitcnt     <= '0;
         shreg      <= '0;
         in_ack     <= 1'b0;
         mack       <= 1'b0;
         dirty      <= 1'b0;
         ptr        <= '0;
         sda_pd     <= 1'b0;
         prog_start <= 1'b0;
      end else begin
         prog_start <= 1'b0;
         if (start_c) begin
            st     <= ST_DEV;
            bitcnt <= '0;
            in_ack <= 1'b0;
            sda_pd <= 1'b0;
         end else if (stop_c) begin
            st     <= ST_IDLE;
            bitcnt <= '0;
            in_ack <= 1'b0;
            sda_pd <= 1'b0;
            if (dirty) begin
               prog_start <= 1'b1;
               dirty      <= 1'b0;
            end
         end else begin
            case (st)
               ST_DEV, ST_ADDR, ST_WDATA: begin
                  if (scl_rise && !in_ack && bitcnt < 4'd8) begin
                     shreg  <= {shreg[6:0], sda_lvl};
                     bitcnt <= bitcnt + 4'd1;
                  end
                  if (byte_done) begin
                     if (st == ST_DEV) begin
                        if (busy || !id_match) begin
                           st <= ST_IDLE;
                        end else begin
                           sda_pd <= 1'b1;
                           in_ack <= 1'b1;
                           ret    <= shreg[0] ? ST_RDATA : ST_ADDR;
                        end
                     end else if (st == ST_ADDR) begin
                        sda_pd <= 1'b1;
                        in_ack <= 1'b1;
                        ptr    <= shreg[AW-1:0];
                        ret    <= ST_WDATA;
                     end else if (wp) begin
                        st <= ST_IDLE;
                     end else begin
                        sda_pd <= 1'b1;
                        in_ack <= 1'b1;
                        ptr    <= ptr + 1'b1;
                        dirty  <= 1'b1;
                        ret    <= ST_WDATA;
                     end
                  end else if (scl_fall && in_ack) begin
                     in_ack <= 1'b0;
                     bitcnt <= '0;
                     st     <= ret;
                     if (ret == ST_RDATA) begin
                        shreg  <= rdata;
                        sda_pd <= ~rdata[7];
                     end else begin
                        sda_pd <= 1'b0;
                     end
                  end
               end
               ST_RDATA: begin
                  if (scl_rise) begin
                     if (in_ack)                 mack   <= ~sda_lvl;
                     else if (bitcnt < 4'd8)     bitcnt <= bitcnt + 4'd1;
                  end
                  if (scl_fall) begin
                     if (in_ack) begin
                        in_ack <= 1'b0;
                        bitcnt <= '0;
                        if (mack) begin
                           shreg  <= rdata;
                           sda_pd <= ~rdata[7];
                        end else begin
                           st <= ST_IDLE;
                        end
                     end else if (bitcnt == 4'd8) begin
                        sda_pd <= 1'b0;
                        in_ack <= 1'b1;
                        ptr    <= ptr + 1'b1;
                     end else if (bitcnt != 4'd0) begin
                        shreg  <= {shreg[6:0], 1'b0};
                        sda_pd <= ~shreg[6];
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R2 / R9: an idle slave never holds the data line
   a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_pd);

   // R4: a busy controller suppresses the addressing acknowledge
   a_r4_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && st == ST_DEV && !in_ack) |=> !sda_pd);

   // R5: protect blocks the data-byte acknowledge
   a_r5_wp_no_data_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (wp && st == ST_WDATA && !in_ack) |=> !sda_pd);

   // R3: program request is a single-cycle pulse issued from idle
   a_r3_prog_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |=> !prog_start);
   a_r3_prog_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> (st == ST_IDLE && !dirty));

   // R11: a START always restarts address decoding
   a_r11_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      start_c |=> (st == ST_DEV && bitcnt == 4'd0 && !sda_pd));
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
   import i2cee_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int STRAP_W     = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic               wp_i,
   input  logic               prog_busy_i,
   output logic               sda_pd_o,
   output logic               prog_start_o
);
   logic              scl_lvl, scl_rise, scl_fall;
   logic              sda_lvl, sda_rise, sda_fall;
   logic [ADDR_W-1:0] ptr;
   logic              we;
   logic [BYTE_W-1:0] wdata, rdata;

   if (ADDR_W > BYTE_W) begin : g_bad_addr
      $error("i2c_eeprom_slave: word address must fit in one byte");
   end

   ee_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i),
      .line_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

   ee_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i),
      .line_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

   ee_slave_ctrl #(.AW(ADDR_W), .STRAP_W(STRAP_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
      .strap(strap_i), .wp(wp_i), .busy(prog_busy_i), .rdata(rdata),
      .ptr(ptr), .we(we), .wdata(wdata),
      .sda_pd(sda_pd_o), .prog_start(prog_start_o));

   ee_regfile #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(ptr), .wdata(wdata),
      .raddr(ptr), .rdata(rdata));
endmodule

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1, m_sda = 1'b1;
   logic [2:0] strap = 3'b101;
   logic       wp = 1'b0;
   logic       prog_busy;
   logic       sda_pd, prog_start;
   logic       sda_line;
   int         bcnt = 0;
   int         n_vec = 0, n_bad = 0, n_prog = 0;
   logic [7:0] mdl [256];
   logic [7:0] mptr = 8'h00;

   always #2 clk = ~clk;

   assign sda_line  = m_sda & ~sda_pd;
   assign prog_busy = (bcnt != 0);

   i2c_eeprom_slave u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .strap_i(strap), .wp_i(wp), .prog_busy_i(prog_busy),
      .sda_pd_o(sda_pd), .prog_start_o(prog_start));

   // stand-in for the program controller
   always @(posedge clk) begin
      if (!rst_n)          bcnt <= 0;
      else if (prog_start) begin bcnt <= 1500; n_prog <= n_prog + 1; end
      else if (bcnt != 0)  bcnt <= bcnt - 1;
   end

   function automatic logic [7:0] sel_byte(input logic [2:0] s, input logic rd);
      return {4'b1010, s, rd};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_x(input logic b, output logic r);
      wt(4); m_sda = b; wt(4); m_scl = 1'b1; wt(4); r = sda_line; wt(4); m_scl = 1'b0;
   endtask

   task automatic bus_start();
      wt(8); m_sda = 1'b1; wt(4); m_scl = 1'b1; wt(8); m_sda = 1'b0; wt(8); m_scl = 1'b0;
   endtask

   task automatic bus_stop();
      wt(8); m_sda = 1'b0; wt(4); m_scl = 1'b1; wt(8); m_sda = 1'b1; wt(8);
   endtask

   task automatic put_byte(input logic [7:0] b, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) bit_x(b[i], r);
      bit_x(1'b1, r);
      ack = ~r;
   endtask

   task automatic get_byte(input logic give_ack, output logic [7:0] d);
      logic r;
      for (int i = 7; i >= 0; i--) begin bit_x(1'b1, r); d[i] = r; end
      bit_x(~give_ack, r);
   endtask

   task automatic wait_ready();
      while (prog_busy) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic       ack, r, quiet;
      logic [7:0] d, a;
      int         n, p0;
      void'($urandom(32'd1234));
      for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
      wt(5); rst_n = 1'b1; wt(5);

      // R10: reset state at the pins
      chk("R10 sda released", sda_pd, 0);
      chk("R10 no prog pulse", prog_start, 0);

      // R6 / R10: current read at reset gives location 0 erased
      bus_start(); put_byte(sel_byte(strap, 1), ack);
      chk("R1 read select ack", ack, 1);
      get_byte(1'b0, d); chk("R10 erased byte", d, 8'hFF); mptr++;
      bus_stop();

      // R2: wrong straps and wrong family code
      bus_start(); put_byte(sel_byte(3'b011, 0), ack);
      chk("R2 strap mismatch nack", ack, 0);
      quiet = 1'b1;
      for (int i = 0; i < 9; i++) begin bit_x(1'b1, r); if (!r) quiet = 1'b0; end
      chk("R2 line stays released", quiet, 1);
      bus_start(); put_byte({4'b1011, strap, 1'b0}, ack);
      chk("R2 family mismatch nack", ack, 0);
      bus_stop();

      // R3 / R4 / R7: random writes, polling, readback
      for (int k = 0; k < 6; k++) begin
         a = 8'($urandom % 256); n = 1 + int'($urandom % 4);
         p0 = n_prog;
         bus_start(); put_byte(sel_byte(strap, 0), ack); chk("R1 write select ack", ack, 1);
         put_byte(a, ack); chk("R3 address ack", ack, 1);
         for (int j = 0; j < n; j++) begin
            d = 8'($urandom);
            put_byte(d, ack); chk("R3 data ack", ack, 1);
            mdl[8'(a + j)] = d;
         end
         mptr = 8'(a + n);
         chk("R3 no pulse before stop", n_prog, p0);
         bus_stop(); wt(2);
         chk("R3 one pulse at stop", n_prog, p0 + 1);
         bus_start(); put_byte(sel_byte(strap, 0), ack);
         chk("R4 busy write-select nack", ack, 0);
         bus_start(); put_byte(sel_byte(strap, 1), ack);
         chk("R4 busy read-select nack", ack, 0);
         bus_stop();
         wait_ready();
         p0 = n_prog;
         bus_start(); put_byte(sel_byte(strap, 0), ack);
         chk("R4 ready poll ack", ack, 1);
         bus_stop(); wt(2);
         chk("R3 no pulse without data", n_prog, p0);
         // R7 random read of first byte
         bus_start(); put_byte(sel_byte(strap, 0), ack); put_byte(a, ack);
         bus_start(); put_byte(sel_byte(strap, 1), ack);
         chk("R7 reselect ack", ack, 1);
         get_byte(1'b0, d); chk("R7 random read data", d, mdl[a]);
         bus_stop(); mptr = 8'(a + 1);
         // R6 current read continues at counter
         bus_start(); put_byte(sel_byte(strap, 1), ack);
         get_byte(1'b0, d); chk("R6 current read data", d, mdl[mptr]);
         bus_stop(); mptr++;
      end

      // R8: sequential read across the top of memory
      bus_start(); put_byte(sel_byte(strap, 0), ack); put_byte(8'hFE, ack);
      for (int j = 0; j < 3; j++) begin
         d = 8'h30 + 8'(j); put_byte(d, ack); mdl[8'(8'hFE + j)] = d;
      end
      bus_stop(); wait_ready();
      bus_start(); put_byte(sel_byte(strap, 0), ack); put_byte(8'hFE, ack);
      bus_start(); put_byte(sel_byte(strap, 1), ack);
      for (int j = 0; j < 4; j++) begin
         get_byte(j != 3, d);
         chk("R8 sequential wrap data", d, mdl[8'(8'hFE + j)]);
      end
      mptr = 8'h02;
      // R9: after the master's nack the slave stays silent
      quiet = 1'b1;
      for (int i = 0; i < 18; i++) begin bit_x(1'b1, r); if (!r) quiet = 1'b0; end
      chk("R9 silent after master nack", quiet, 1);
      bus_stop();

      // R5: write protect
      wp = 1'b1; p0 = n_prog; a = 8'h40;
      bus_start(); put_byte(sel_byte(strap, 0), ack); chk("R5 select ack", ack, 1);
      put_byte(a, ack); chk("R5 address ack", ack, 1);
      put_byte(8'h5A, ack); chk("R5 data nack", ack, 0);
      bus_stop(); wt(2);
      chk("R5 no program pulse", n_prog, p0);
      wp = 1'b0;
      bus_start(); put_byte(sel_byte(strap, 0), ack); put_byte(a, ack);
      bus_start(); put_byte(sel_byte(strap, 1), ack);
      get_byte(1'b0, d); chk("R5 memory unchanged", d, mdl[a]);
      bus_stop(); mptr = 8'(a + 1);

      // R11: START inside a byte restarts decoding
      bus_start(); d = sel_byte(strap, 1);
      for (int i = 7; i >= 4; i--) bit_x(d[i], r);
      bus_start(); put_byte(sel_byte(strap, 1), ack);
      chk("R11 restart select ack", ack, 1);
      get_byte(1'b0, d); chk("R11 restart read data", d, mdl[mptr]);
      bus_stop(); wt(4);
      chk("R11 idle after stop", sda_pd, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule